// File: doc/BRIEF.md
# Quadword Unsigned Add/Subtract Unit

This execution unit performs 128-bit unsigned addition and subtraction in eight forms. Add and subtract each come as a plain modulo form, a carry-reporting form, an extended modulo form and an extended carry-reporting form. The extended forms take their carry-in from the least significant bit of a third operand vector. The carry-reporting forms return the carry-out as a full-width vector: the carry sits in bit 0 and every other bit is zero.

All eight forms share one carry-propagate adder. Subtraction adds the bitwise complement of B. The carry-in comes from C[0] for the extended forms, is 1 for plain subtraction, and is 0 for plain addition. One register stage captures the result, so a valid input appears at the outputs one clock later. No back-pressure exists. An operation select value the unit does not recognise gives a zero result and raises an illegal flag together with valid_out.

Top module: `qw_addsub_unit`

## Requirements
- R1: Operation select 4 gives result = (A + B) mod 2^128; any carry out of bit 127 is dropped.
- R2: Operation select 20 gives result = (A - B) mod 2^128, computed as A + ~B + 1.
- R3: Operation select 5 gives result[0] = 1 exactly when A + B exceeds 2^128 - 1 (equivalently ~A < B), with result[127:1] = 0.
- R4: Operation select 21 gives result[0] = 1 exactly when A >= B unsigned (no borrow), with result[127:1] = 0.
- R5: Operation select 30 is extended add. With sub_sel = 0 the result is (A + B + C[0]) mod 2^128. With sub_sel = 1, result[0] = 1 when A + B overflows, or when C[0] = 1 and A + B equals all ones; the upper 127 bits are zero.
- R6: Operation select 31 is extended subtract. With sub_sel = 0 the result is (A + ~B + C[0]) mod 2^128. With sub_sel = 1, result[0] = 1 when A > B, or when C[0] = 1 and A = B; the upper 127 bits are zero.
- R7: Only C[0] affects any result. C[127:1] never has an effect, and C has no effect at all on operation selects 4, 5, 20 and 21.
- R8: sub_sel has no effect on operation selects 4, 5, 20 and 21.
- R9: valid_out is high in the cycle after a cycle with valid_in high, and low otherwise. result and illegal_op change only after a cycle with valid_in high; otherwise they hold their values.
- R10: While reset is held, valid_out, illegal_op and result are all zero.
- R11: Any operation select other than 4, 5, 20, 21, 30 and 31 gives result = 0 and illegal_op = 1 together with valid_out. Legal selects give illegal_op = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_in | input | 1 | Operands and select are valid this cycle |
| op_sel | input | 5 | Operation select code |
| sub_sel | input | 1 | Extended forms: 0 = modulo result, 1 = carry result |
| opnd_a | input | 128 | Operand A |
| opnd_b | input | 128 | Operand B |
| opnd_c | input | 128 | Carry operand; only bit 0 is used |
| valid_out | output | 1 | Result valid, one cycle after valid_in |
| result | output | 128 | Modulo sum/difference or zero-extended carry |
| illegal_op | output | 1 | Operation select was not recognised |

## Verification
The result register is the only state of any width. A wrong decode or carry-in choice therefore appears in result on the very cycle valid_out rises for the affected operation, and shows up as an off-by-one sum or a flipped bit 0. Operand pairs that sit on the carry boundary (A + B equal to all ones, A equal to B) separate a wrong carry-in from a wrong comparison. A stuck or leaking valid register shows up within one cycle of an idle gap, when valid_out fails to drop or result moves without a request.

// File: rtl/qw_addsub_unit.sv
module qw_addsub_unit #(
  parameter int WIDTH = 128,
  parameter int OPW   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid_in,
  input  logic [OPW-1:0]   op_sel,
  input  logic             sub_sel,
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  input  logic [WIDTH-1:0] opnd_c,
  output logic             valid_out,
  output logic [WIDTH-1:0] result,
  output logic             illegal_op
);

  localparam logic [OPW-1:0] OP_ADD_M = OPW'(4);
  localparam logic [OPW-1:0] OP_ADD_C = OPW'(5);
  localparam logic [OPW-1:0] OP_SUB_M = OPW'(20);
  localparam logic [OPW-1:0] OP_SUB_C = OPW'(21);
  localparam logic [OPW-1:0] OP_ADD_X = OPW'(30);
  localparam logic [OPW-1:0] OP_SUB_X = OPW'(31);

  logic             is_sub, use_cin, want_carry, legal;
  logic             cin;
  logic [WIDTH-1:0] b_eff;
  logic [WIDTH:0]   sum;
  logic [WIDTH-1:0] next_res;
  logic             unused_c_hi;

  always_comb begin
    is_sub     = 1'b0;
    use_cin    = 1'b0;
    want_carry = 1'b0;
    legal      = 1'b1;
    case (op_sel)
      OP_ADD_M: ;
      OP_ADD_C: want_carry = 1'b1;
      OP_SUB_M: is_sub = 1'b1;
      OP_SUB_C: begin is_sub = 1'b1; want_carry = 1'b1; end
      OP_ADD_X: begin use_cin = 1'b1; want_carry = sub_sel; end
      OP_SUB_X: begin is_sub = 1'b1; use_cin = 1'b1; want_carry = sub_sel; end
      default:  legal = 1'b0;
    endcase
  end

  assign b_eff       = is_sub ? ~opnd_b : opnd_b;
  assign cin         = use_cin ? opnd_c[0] : is_sub;
  assign sum         = {1'b0, opnd_a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, cin};
  assign next_res    = !legal     ? '0 :
                       want_carry ? {{(WIDTH-1){1'b0}}, sum[WIDTH]} :
                                    sum[WIDTH-1:0];
  assign unused_c_hi = ^opnd_c[WIDTH-1:1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_out  <= 1'b0;
      result     <= '0;
      illegal_op <= 1'b0;
    end else begin
      valid_out <= valid_in;
      if (valid_in) begin
        result     <= next_res;
        illegal_op <= !legal;
      end
    end
  end

  p_add_mod_r1: assert property (@(posedge clk) disable iff (!rst_n)
    valid_in && op_sel == OP_ADD_M |=> result - $past(opnd_b) == $past(opnd_a));

  p_sub_mod_r2: assert property (@(posedge clk) disable iff (!rst_n)
    valid_in && op_sel == OP_SUB_M |=> result + $past(opnd_b) == $past(opnd_a));

  p_add_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    valid_in && op_sel == OP_ADD_C |=> result[0] == ($past(opnd_b) > ~$past(opnd_a)));

  p_sub_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    valid_in && op_sel == OP_SUB_C |=> result[0] == ($past(opnd_a) >= $past(opnd_b)));

  p_xsub_carry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    valid_in && op_sel == OP_SUB_X && sub_sel |=>
      result[0] == (($past(opnd_a) > $past(opnd_b)) ||
                    ($past(opnd_c[0]) && $past(opnd_a) == $past(opnd_b))));

  p_carry_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    valid_in && (op_sel == OP_ADD_C || op_sel == OP_SUB_C ||
                 ((op_sel == OP_ADD_X || op_sel == OP_SUB_X) && sub_sel))
      |=> result[WIDTH-1:1] == '0);

  p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    valid_in |=> valid_out);

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_in |=> !valid_out && $stable(result) && $stable(illegal_op));

  p_illegal_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    valid_out && illegal_op |-> result == '0);

endmodule

// File: tb/qw_addsub_unit_tb_top.sv
module qw_addsub_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 128;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         valid_in = 1'b0;
  logic [4:0]   op_sel = '0;
  logic         sub_sel = 1'b0;
  logic [W-1:0] opnd_a = '0, opnd_b = '0, opnd_c = '0;
  logic         valid_out;
  logic [W-1:0] result;
  logic         illegal_op;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] exp_res_q[$];
  logic         exp_ill_q[$];
  string        tag_q[$];
  logic [W-1:0] last_res;
  logic         last_ill;
  logic [W-1:0] ONES;

  always #(CLK_PERIOD/2) clk = ~clk;

  qw_addsub_unit dut_i (
    .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .op_sel(op_sel),
    .sub_sel(sub_sel), .opnd_a(opnd_a), .opnd_b(opnd_b), .opnd_c(opnd_c),
    .valid_out(valid_out), .result(result), .illegal_op(illegal_op)
  );

  function automatic void model(input logic [4:0] op, input logic ss,
                                input logic [W-1:0] a, b, c,
                                output logic [W-1:0] r, output logic ill);
    logic cy;
    ill = 1'b0;
    r   = '0;
    case (op)
      5'd4:  r = a + b;
      5'd20: r = a - b;
      5'd5:  r = {{(W-1){1'b0}}, (~a < b)};
      5'd21: r = {{(W-1){1'b0}}, (a >= b)};
      5'd30: begin
        cy = (~a < b) || (c[0] && (a + b) == {W{1'b1}});
        r  = ss ? {{(W-1){1'b0}}, cy} : a + b + {{(W-1){1'b0}}, c[0]};
      end
      5'd31: begin
        cy = (a > b) || (c[0] && a == b);
        r  = ss ? {{(W-1){1'b0}}, cy} : a - b - 1 + {{(W-1){1'b0}}, c[0]};
      end
      default: ill = 1'b1;
    endcase
  endfunction

  task automatic check(input string tag, input logic [W-1:0] act, exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp_v);
    end
  endtask

  task automatic send(input logic [4:0] op, input logic ss,
                      input logic [W-1:0] a, b, c, input string tag);
    logic [W-1:0] r;
    logic ill;
    model(op, ss, a, b, c, r, ill);
    @(negedge clk);
    exp_res_q.push_back(r);
    exp_ill_q.push_back(ill);
    tag_q.push_back(tag);
    op_sel = op; sub_sel = ss; opnd_a = a; opnd_b = b; opnd_c = c;
    valid_in = 1'b1;
  endtask

  function automatic logic [W-1:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  always @(negedge clk) begin
    if (rst_n && valid_out) begin
      if (exp_res_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R9: actual valid_out 1 expected 0 (nothing pending)");
      end else begin
        string t;
        t = tag_q.pop_front();
        check(t, result, exp_res_q.pop_front());
        check({t, " R11 flag"}, {{(W-1){1'b0}}, illegal_op},
              {{(W-1){1'b0}}, exp_ill_q.pop_front()});
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    ONES = {W{1'b1}};
    repeat (3) @(negedge clk);
    check("R10 valid_out", {{(W-1){1'b0}}, valid_out}, '0);
    check("R10 result", result, '0);
    check("R10 illegal_op", {{(W-1){1'b0}}, illegal_op}, '0);
    rst_n = 1'b1;

    send(5'd4,  1'b0, ONES, 128'd1, '0, "R1 wrap");
    send(5'd4,  1'b1, 128'h5, 128'h7, ONES, "R1 R7 R8 ignore");
    send(5'd20, 1'b0, 128'd0, 128'd1, '0, "R2 borrow wrap");
    send(5'd20, 1'b1, 128'd9, 128'd4, ONES, "R2 R8");
    send(5'd5,  1'b0, ONES, 128'd1, '0, "R3 overflow");
    send(5'd5,  1'b1, ONES, 128'd0, ONES, "R3 R8 no overflow");
    send(5'd21, 1'b0, 128'd7, 128'd7, '0, "R4 equal");
    send(5'd21, 1'b0, 128'd6, 128'd7, ONES, "R4 R7 less");
    send(5'd30, 1'b0, ONES, 128'd0, 128'd1, "R5 mod cin wrap");
    send(5'd30, 1'b1, ONES, 128'd0, 128'd1, "R5 carry via cin");
    send(5'd30, 1'b1, ONES, 128'd0, ~128'd1, "R7 upper C ignored");
    send(5'd31, 1'b0, 128'd3, 128'd3, 128'd0, "R6 mod no cin");
    send(5'd31, 1'b1, 128'd3, 128'd3, 128'd1, "R6 equal cin");
    send(5'd31, 1'b1, 128'd3, 128'd3, ~128'd1, "R6 R7 equal no cin");
    send(5'd31, 1'b1, 128'd4, 128'd3, 128'd0, "R6 greater");
    send(5'd0,  1'b0, ONES, ONES, ONES, "R11 illegal 0");
    send(5'd22, 1'b1, ONES, ONES, ONES, "R11 illegal 22");
    for (int i = 0; i < 40; i++) begin
      logic [4:0] ops [6] = '{5'd4, 5'd5, 5'd20, 5'd21, 5'd30, 5'd31};
      logic [W-1:0] a;
      a = rnd128();
      send(ops[i % 6], 1'($urandom), a, (i % 5 == 0) ? a : rnd128(),
           rnd128(), "R1 R2 R3 R4 R5 R6 random");
    end
    send(5'd4, 1'b0, 128'h1234, 128'h1, '0, "R1 before idle");
    @(negedge clk);
    valid_in = 1'b0;
    opnd_a = ONES; op_sel = 5'd0;
    last_res = 128'h1235;
    last_ill = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R9 valid_out low when idle", {{(W-1){1'b0}}, valid_out}, '0);
    check("R9 result held", result, last_res);
    check("R9 illegal_op held", {{(W-1){1'b0}}, illegal_op}, {{(W-1){1'b0}}, last_ill});
    if (exp_res_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R9: actual %0d pending expected 0", exp_res_q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule